// File: doc/BRIEF.md
# Indexed element remap generator

This block drives a vector loop one element at a time. For each element it produces a register number for each of three operands: first source, second source and destination. Each operand picks one of four programmable shapes. An index shape reads a small index packed into a 64-bit register-file word, which the block fetches through its own read ports. A modulo shape returns the element number wrapped by a configured count. The block adds the chosen index to the operand's vector base register and flags any result that falls outside the register file.

Software sets a vector length of up to 32 elements. This also clears the element counter and the end flag. It then issues one step per element, and an external branch leaves the loop once the end flag rises. After reset the vector length is 32. The offsets are registered one cycle after the counter or the configuration changes, and a ready output marks when they are valid. The register file itself and the execution units sit outside the block.

Top module: `remap_idx_gen`

## Requirements
- R1: After reset, elem_o is 0, end_o is 0 and ready_o is 0.
- R2: A cycle with vl_we_i high loads the vector length, returns elem_o to 0 and clears end_o. A written value of 0 is taken as 1 and a value above 32 is taken as 32.
- R3: A step_i pulse advances elem_o by one. A step while elem_o equals length minus one raises end_o and leaves elem_o unchanged. Steps while end_o is high change neither elem_o nor end_o.
- R4: ready_o is low in the cycle after any cycle in which vl_we_i, step_i, shp_we_i or map_we_i is high, and high after a cycle in which none of them is. While ready_o is high, eff_o and err_o belong to the current elem_o and configuration.
- R5: An index shape's width code 0, 1, 2 or 3 selects 64-, 32-, 16- or 8-bit indices. Element e sits in table word e>>code, in field e mod 2^code counted from the least significant end.
- R6: For an index shape, an operand's read address rd_addr_o is twice the shape's start field plus e>>code, taken modulo 128.
- R7: A modulo shape yields e mod m, where m is its modulo field. When m is 0, it yields e.
- R8: map_i bits 1:0 give the shape number of the first source, bits 3:2 that of the second source and bits 5:4 that of the destination. The three selections are independent.
- R9: Each operand's eff_o lane (7 bits; lane 0 first source, lane 1 second source, lane 2 destination) equals its vbase_i lane plus the selected index.
- R10: An operand's err_o bit is set when index plus base is 128 or more. Its eff_o lane then holds the low 7 bits of that sum.
- R11: When vl_we_i and step_i are high in the same cycle, the length write takes effect and the step is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vl_we_i | input | 1 | Load vector length, restart loop |
| vl_i | input | 6 | Vector length value |
| step_i | input | 1 | Advance to next element |
| shp_we_i | input | 1 | Write one shape |
| shp_sel_i | input | 2 | Shape number to write |
| shp_mod_en_i | input | 1 | 1: modulo shape, 0: index shape |
| shp_ewid_i | input | 2 | Index width code |
| shp_half_i | input | 6 | Table start register divided by two |
| shp_modv_i | input | 6 | Modulo count |
| map_we_i | input | 1 | Write operand-to-shape map |
| map_i | input | 6 | Shape numbers for src1, src2, dst |
| vbase_i | input | 21 | Vector base register per operand, 7 bits each |
| rd_addr_o | output | 21 | Index word read address per operand |
| rd_data_i | input | 192 | Index word read data per operand, 64 bits each |
| elem_o | output | 5 | Current element number |
| end_o | output | 1 | Last element processed |
| ready_o | output | 1 | Offsets valid |
| eff_o | output | 21 | Effective register per operand |
| err_o | output | 3 | Out-of-range flag per operand |

## Verification
The first loop walks all 32 elements with 8-bit tables and a modulo-4 shape, each on a different operand. It separates byte ordering inside a word from word stepping across four words, and a swapped operand map shows up at once. A second loop holds a 64-, a 32- and a 16-bit table at the same time, which exposes a wrong field shift or mask for each width. Further runs use modulo 3 and modulo 0, length writes of 0 and 40, tables that land past register 127, and a length write that coincides with a step. These cover the clamp rules, the error flag and the priority between length write and step.

// File: rtl/remap_pkg.sv
package remap_pkg;
  localparam int REG_W  = 7;
  localparam int MAXVL  = 32;
  localparam int ELEM_W = $clog2(MAXVL);
  localparam int VL_W   = ELEM_W + 1;
  localparam int XLEN   = 64;
  localparam int NSHAPE = 4;
  localparam int SEL_W  = $clog2(NSHAPE);
  localparam int NOPS   = 3;

  typedef struct packed {
    logic              mod_en;
    logic [1:0]        ewid;
    logic [REG_W-2:0]  half;
    logic [VL_W-1:0]   modv;
  } shape_t;
endpackage

// File: rtl/remap_step_ctr.sv
module remap_step_ctr
  import remap_pkg::*;
#(
  parameter int MAX_LEN = MAXVL,
  localparam int EW = $clog2(MAX_LEN),
  localparam int LW = EW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vl_we_i,
  input  logic [LW-1:0] vl_i,
  input  logic          step_i,
  output logic [EW-1:0] elem_o,
  output logic          end_o
);
  logic [LW-1:0] vl_q, vl_eff;
  logic [EW-1:0] elem_q;
  logic          end_q;

  always_comb begin
    if (vl_i == '0)                 vl_eff = LW'(1);
    else if (vl_i > LW'(MAX_LEN))   vl_eff = LW'(MAX_LEN);
    else                            vl_eff = vl_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vl_q   <= LW'(MAX_LEN);
      elem_q <= '0;
      end_q  <= 1'b0;
    end else if (vl_we_i) begin
      vl_q   <= vl_eff;
      elem_q <= '0;
      end_q  <= 1'b0;
    end else if (step_i && !end_q) begin
      if (LW'(elem_q) == vl_q - LW'(1)) end_q <= 1'b1;
      else                              elem_q <= elem_q + EW'(1);
    end
  end

  assign elem_o = elem_q;
  assign end_o  = end_q;
endmodule

// File: rtl/remap_shape_bank.sv
module remap_shape_bank
  import remap_pkg::*;
#(
  parameter int N_SHAPE = NSHAPE,
  parameter int N_OPS   = NOPS,
  localparam int SW = $clog2(N_SHAPE)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      shp_we_i,
  input  logic [SW-1:0]             shp_sel_i,
  input  shape_t                    shp_i,
  input  logic                      map_we_i,
  input  logic [N_OPS*SW-1:0]       map_i,
  output shape_t [N_OPS-1:0]        op_shp_o
);
  shape_t        shp_q [N_SHAPE];
  logic [SW-1:0] map_q [N_OPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_SHAPE; s++) shp_q[s] <= '0;
      for (int o = 0; o < N_OPS; o++)   map_q[o] <= '0;
    end else begin
      if (shp_we_i) shp_q[shp_sel_i] <= shp_i;
      if (map_we_i)
        for (int o = 0; o < N_OPS; o++) map_q[o] <= map_i[o*SW +: SW];
    end
  end

  for (genvar o = 0; o < N_OPS; o++) begin : g_sel
    assign op_shp_o[o] = shp_q[map_q[o]];
  end
endmodule

// File: rtl/remap_lane.sv
module remap_lane
  import remap_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ELEM_W-1:0] elem_i,
  input  shape_t           shp_i,
  input  logic [REG_W-1:0] vbase_i,
  input  logic [XLEN-1:0]  rd_data_i,
  output logic [REG_W-1:0] rd_addr_o,
  output logic [REG_W-1:0] eff_o,
  output logic             err_o
);
  logic [ELEM_W-1:0] word_off, pos;
  logic [5:0]        sh;
  logic [XLEN-1:0]   raw, fld, idx;
  logic [VL_W-1:0]   ev, mres;
  logic [REG_W:0]    sum;
  logic              err_c;

  always_comb begin
    word_off  = elem_i >> shp_i.ewid;
    pos       = elem_i & ~({ELEM_W{1'b1}} << shp_i.ewid);
    rd_addr_o = {shp_i.half, 1'b0} + REG_W'(word_off);
    // field width is 64 >> ewid bits
    sh  = 6'(pos) << (3'd6 - {1'b0, shp_i.ewid});
    raw = rd_data_i >> sh;
    case (shp_i.ewid)
      2'd0:    fld = raw;
      2'd1:    fld = {32'b0, raw[31:0]};
      2'd2:    fld = {48'b0, raw[15:0]};
      default: fld = {56'b0, raw[7:0]};
    endcase
    ev   = VL_W'(elem_i);
    mres = (shp_i.modv == '0) ? ev : ev % shp_i.modv;
    idx  = shp_i.mod_en ? XLEN'(mres) : fld;
    sum  = {1'b0, vbase_i} + {1'b0, idx[REG_W-1:0]};
    err_c = (|idx[XLEN-1:REG_W]) | sum[REG_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eff_o <= '0;
      err_o <= 1'b0;
    end else begin
      eff_o <= sum[REG_W-1:0];
      err_o <= err_c;
    end
  end
endmodule

// File: rtl/remap_idx_gen.sv
module remap_idx_gen
  import remap_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   vl_we_i,
  input  logic [VL_W-1:0]        vl_i,
  input  logic                   step_i,
  input  logic                   shp_we_i,
  input  logic [SEL_W-1:0]       shp_sel_i,
  input  logic                   shp_mod_en_i,
  input  logic [1:0]             shp_ewid_i,
  input  logic [REG_W-2:0]       shp_half_i,
  input  logic [VL_W-1:0]        shp_modv_i,
  input  logic                   map_we_i,
  input  logic [NOPS*SEL_W-1:0]  map_i,
  input  logic [NOPS*REG_W-1:0]  vbase_i,
  output logic [NOPS*REG_W-1:0]  rd_addr_o,
  input  logic [NOPS*XLEN-1:0]   rd_data_i,
  output logic [ELEM_W-1:0]      elem_o,
  output logic                   end_o,
  output logic                   ready_o,
  output logic [NOPS*REG_W-1:0]  eff_o,
  output logic [NOPS-1:0]        err_o
);
  shape_t              wr_shp;
  shape_t [NOPS-1:0]   op_shp;
  logic                rdy_q;

  assign wr_shp = '{mod_en: shp_mod_en_i, ewid: shp_ewid_i,
                    half: shp_half_i, modv: shp_modv_i};

  remap_step_ctr #(.MAX_LEN(MAXVL)) u_ctr (
    .clk_i, .rst_ni, .vl_we_i, .vl_i, .step_i,
    .elem_o, .end_o
  );

  remap_shape_bank #(.N_SHAPE(NSHAPE), .N_OPS(NOPS)) u_bank (
    .clk_i, .rst_ni, .shp_we_i, .shp_sel_i, .shp_i(wr_shp),
    .map_we_i, .map_i, .op_shp_o(op_shp)
  );

  for (genvar o = 0; o < NOPS; o++) begin : g_lane
    remap_lane u_lane (
      .clk_i, .rst_ni,
      .elem_i    (elem_o),
      .shp_i     (op_shp[o]),
      .vbase_i   (vbase_i[o*REG_W +: REG_W]),
      .rd_data_i (rd_data_i[o*XLEN +: XLEN]),
      .rd_addr_o (rd_addr_o[o*REG_W +: REG_W]),
      .eff_o     (eff_o[o*REG_W +: REG_W]),
      .err_o     (err_o[o])
    );
  end

  // offsets trail counter/config by one register stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdy_q <= 1'b0;
    else         rdy_q <= !(vl_we_i || step_i || shp_we_i || map_we_i);
  end
  assign ready_o = rdy_q;
endmodule

// File: rtl/remap_idx_gen_chk.sv
module remap_idx_gen_chk
  import remap_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vl_we_i,
  input logic              step_i,
  input logic              shp_we_i,
  input logic              map_we_i,
  input logic [ELEM_W-1:0] elem_o,
  input logic              end_o,
  input logic              ready_o
);
  // R2
  vl_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vl_we_i |=> (elem_o == '0 && !end_o));

  // R3
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !vl_we_i && !end_o) |=> (end_o || elem_o == ELEM_W'($past(elem_o) + 1'b1)));

  // R3
  end_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_o && !vl_we_i) |=> (end_o && $stable(elem_o)));

  // R4
  rdy_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vl_we_i || step_i || shp_we_i || map_we_i) |=> !ready_o);

  // R4
  rdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vl_we_i || step_i || shp_we_i || map_we_i) |=> ready_o);
endmodule

bind remap_idx_gen remap_idx_gen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .vl_we_i(vl_we_i), .step_i(step_i),
  .shp_we_i(shp_we_i), .map_we_i(map_we_i), .elem_o(elem_o),
  .end_o(end_o), .ready_o(ready_o)
);

// File: tb/remap_idx_gen_test.sv
`timescale 1ns/1ps
module remap_idx_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        vl_we_i = 0, step_i = 0, shp_we_i = 0, map_we_i = 0;
  logic [5:0]  vl_i = '0;
  logic [1:0]  shp_sel_i = '0, shp_ewid_i = '0;
  logic        shp_mod_en_i = 0;
  logic [5:0]  shp_half_i = '0, shp_modv_i = '0;
  logic [5:0]  map_i = '0;
  logic [20:0] vbase_i = '0;
  logic [20:0] rd_addr_o;
  logic [191:0] rd_data_i;
  logic [4:0]  elem_o;
  logic        end_o, ready_o;
  logic [20:0] eff_o;
  logic [2:0]  err_o;

  always #10 clk_i = ~clk_i;

  remap_idx_gen uut (.*);

  logic [63:0] mem [128];
  always_comb
    for (int o = 0; o < 3; o++) rd_data_i[o*64 +: 64] = mem[rd_addr_o[o*7 +: 7]];

  typedef struct packed {
    logic [4:0]  elem;
    logic        endf;
    logic [20:0] eff;
    logic [2:0]  err;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    pend = 0;
  int    n_chk = 0, n_fail = 0;

  int m_elem = 0, m_vl = 32;
  bit m_end = 0;
  bit m_mod[4];
  int m_ew[4], m_half[4], m_modv[4], m_map[3], m_vb[3];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] e_idx(int s, int e);
    logic [63:0] word, v;
    int w, bits, fld;
    if (m_mod[s]) return (m_modv[s] == 0) ? 64'(e) : 64'(e % m_modv[s]);
    w    = m_ew[s];
    word = mem[(2*m_half[s] + (e >> w)) % 128];
    fld  = e % (1 << w);
    bits = 64 >> w;
    v    = word >> (fld * bits);
    if (bits < 64) v = v & ((64'd1 << bits) - 64'd1);
    return v;
  endfunction

  function automatic exp_t model();
    exp_t x;
    logic [64:0] s;
    x.elem = 5'(m_elem);
    x.endf = m_end;
    for (int o = 0; o < 3; o++) begin
      s = {1'b0, e_idx(m_map[o], m_elem)} + 65'(m_vb[o]);
      x.eff[o*7 +: 7] = s[6:0];
      x.err[o] = (s >= 65'd128);
    end
    return x;
  endfunction

  // monitor: pops one expectation each time offsets are valid
  always @(negedge clk_i) begin
    if (rst_ni && ready_o && pend != 0) begin
      exp_t  x;
      string t;
      x = q.pop_front();
      t = tq.pop_front();
      chk({t, " elem"}, 64'(elem_o), 64'(x.elem));
      chk({t, " end"},  64'(end_o),  64'(x.endf));
      chk({t, " eff"},  64'(eff_o),  64'(x.eff));
      chk({t, " err"},  64'(err_o),  64'(x.err));
      pend--;
    end
  end

  task automatic settle(string tag);
    @(negedge clk_i);
    vl_we_i = 0; step_i = 0; shp_we_i = 0; map_we_i = 0;
    chk({tag, " R4 ready low after action"}, 64'(ready_o), 64'd0);
    q.push_back(model());
    tq.push_back(tag);
    pend++;
    wait (pend == 0);
  endtask

  task automatic m_setvl(int v);
    m_vl = (v == 0) ? 1 : (v > 32 ? 32 : v);
    m_elem = 0; m_end = 0;
  endtask

  task automatic m_step();
    if (!m_end) begin
      if (m_elem == m_vl - 1) m_end = 1;
      else m_elem++;
    end
  endtask

  task automatic do_vl(int v, string tag);
    @(negedge clk_i);
    vl_we_i = 1; vl_i = 6'(v);
    m_setvl(v);
    settle(tag);
  endtask

  task automatic do_step(string tag);
    @(negedge clk_i);
    step_i = 1;
    m_step();
    settle(tag);
  endtask

  task automatic do_shape(int s, bit md, int ew, int hf, int mv, string tag);
    @(negedge clk_i);
    shp_we_i = 1; shp_sel_i = 2'(s); shp_mod_en_i = md;
    shp_ewid_i = 2'(ew); shp_half_i = 6'(hf); shp_modv_i = 6'(mv);
    m_mod[s] = md; m_ew[s] = ew; m_half[s] = hf; m_modv[s] = mv;
    settle(tag);
  endtask

  task automatic do_map(int a, int b, int c, string tag);
    @(negedge clk_i);
    map_we_i = 1; map_i = {2'(c), 2'(b), 2'(a)};
    m_map[0] = a; m_map[1] = b; m_map[2] = c;
    settle(tag);
  endtask

  task automatic set_vb(int a, int b, int c);
    @(negedge clk_i);
    vbase_i = {7'(c), 7'(b), 7'(a)};
    m_vb[0] = a; m_vb[1] = b; m_vb[2] = c;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    for (int r = 0; r < 128; r++) begin
      mem[r] = '0;
      if (r >= 8 && r < 24)
        for (int k = 0; k < 8; k++) mem[r][k*8 +: 8] = 8'((r*13 + k*7) % 16);
      else if (r >= 40 && r < 72) mem[r] = 64'((r*3) % 29);
      else if (r >= 80 && r < 96) mem[r] = {32'((r*5) % 17), 32'((r*11) % 23)};
      else if (r >= 96 && r < 104)
        for (int k = 0; k < 4; k++) mem[r][k*16 +: 16] = 16'((r + k*9) % 31);
      else if (r >= 120 && r < 124) mem[r] = '1;
    end
    for (int s = 0; s < 4; s++) begin m_mod[s] = 0; m_ew[s] = 0; m_half[s] = 0; m_modv[s] = 0; end
    for (int o = 0; o < 3; o++) begin m_map[o] = 0; m_vb[o] = 0; end

    rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset elem", 64'(elem_o), 64'd0);
    chk("R1 reset end", 64'(end_o), 64'd0);
    chk("R1 reset ready", 64'(ready_o), 64'd0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    chk("R4 ready idle", 64'(ready_o), 64'd1);

    // 8-bit tables on two operands, modulo 4 on the third
    set_vb(24, 24, 0);
    do_shape(0, 0, 3, 4, 0, "R5 cfg");
    do_shape(1, 0, 3, 6, 0, "R5 cfg");
    do_shape(3, 1, 0, 0, 4, "R7 cfg");
    do_map(1, 0, 3, "R8 map");
    do_vl(32, "R2 vl 32");
    for (int i = 0; i < 32; i++) begin
      do_step("R3 R5 R7 R8 R9 walk32");
      if (i == 8) chk("R6 src1 read address", 64'(rd_addr_o[6:0]), 64'd13);
    end
    do_step("R3 step after end ignored");

    // 64-, 32- and 16-bit tables together
    set_vb(0, 16, 32);
    do_shape(0, 0, 0, 20, 0, "R5 cfg64");
    do_shape(1, 0, 1, 40, 0, "R5 cfg32");
    do_shape(2, 0, 2, 48, 0, "R5 cfg16");
    do_map(0, 1, 2, "R8 map");
    do_vl(7, "R2 vl 7");
    for (int i = 0; i < 7; i++) begin
      do_step("R3 R5 R9 widths");
      if (i == 2) chk("R6 src2 read address", 64'(rd_addr_o[13:7]), 64'd81);
    end

    // modulo 3 and modulo 0, clamped lengths
    set_vb(10, 20, 30);
    do_shape(3, 1, 0, 0, 3, "R7 cfg mod3");
    do_shape(2, 1, 0, 0, 0, "R7 cfg mod0");
    do_map(3, 2, 3, "R8 map");
    do_vl(40, "R2 vl 40 clamps");
    for (int i = 0; i < 5; i++) do_step("R7 modulo");
    do_vl(0, "R2 vl 0 as 1");
    do_step("R2 single element end");
    do_step("R3 ignored after end");

    // out-of-range effective registers
    set_vb(0, 0, 120);
    do_shape(0, 0, 3, 4, 0, "R10 cfg");
    do_shape(1, 0, 0, 60, 0, "R10 cfg");
    do_map(0, 1, 0, "R10 map");
    do_vl(8, "R10 vl");
    for (int i = 0; i < 8; i++) do_step("R10 range error");

    // length write and step together
    do_vl(10, "R11 vl");
    for (int i = 0; i < 3; i++) do_step("R11 pre");
    @(negedge clk_i);
    vl_we_i = 1; step_i = 1; vl_i = 6'd6;
    m_setvl(6);
    settle("R11 vl wins over step");
    do_step("R11 after");

    repeat (2) @(negedge clk_i);
    summary();
  end
endmodule